// File: doc/BRIEF.md
# Frequency-Ordered Symbol Ranker

This block turns a stream of small fixed-width symbols into positions within a self-organising ordered list, so that symbols that occur often end up near the top and receive small rank values. A downstream variable-length coder can then give short codes to small ranks. Each accepted symbol is looked up in every list slot at once, its current slot number is returned as the rank, and in the same clock edge the list is reordered so the symbol climbs one frequency tier.

The list is divided into tiers by a small set of boundary registers. Boundary `j` holds the number of list entries that have been seen at least `j+1` times, so the tiers are contiguous slices of the list with the most frequent slice at position 0. A hit in a tier below the top is exchanged with the first entry of that tier, and that tier's boundary grows by one. A hit already in the top tier is exchanged with its upper neighbour only. Symbols outside the loaded value range produce a fixed miss code and leave the list alone.

Input and output both use a valid/ready handshake; one result is held at a time.

Top module: `rank_list_top`

## Requirements
- R1: After reset the list holds value `i` at position `i` for every `i` below `N`, every tier boundary is 0 and `out_valid` is low; the first symbol `s < N` after reset returns rank `s`.
- R2: The rank returned for an accepted symbol is the position it held before that symbol's reorder; the reorder is complete before the next symbol is accepted.
- R3: For a hit whose count tier `c` (the number of boundaries strictly greater than its position) is below `K`, the symbol is swapped with the entry at position `boundary[c]` and `boundary[c]` rises by one; all other boundaries keep their values.
- R4: For a hit with `c == K` (top tier), the symbol is swapped with the entry one position above it (no change at position 0) and no boundary changes.
- R5: A symbol with value `N` or greater returns the miss code, all ones in the rank width `$clog2(N+1)`, and changes neither the list nor any boundary.
- R6: `in_ready` is high exactly when no result is held or the held result is being taken; while `out_valid` is high and `out_ready` is low, `out_rank` and the boundaries stay unchanged.
- R7: The boundaries stay ordered, `boundary[j+1] <= boundary[j] <= N`, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Block can take a symbol this cycle |
| in_sym | input | SW | Symbol value |
| out_valid | output | 1 | A rank is held |
| out_ready | input | 1 | Consumer takes the held rank |
| out_rank | output | $clog2(N+1) | Pre-reorder position, or all ones on a miss |

## Verification
The bench drives a 16-entry, 3-tier configuration. A per-reset sweep of every in-range symbol separates a correct initial load from any shifted or reversed one, and short hand-worked sequences pin tier promotion against top-tier transposition. A repeated single symbol shows the climb through every tier, while long pseudo-random streams over the full 5-bit range, a narrow skewed range and an ascending scan mix misses, promotions and transpositions against an independent list model. A stalled output with a second symbol waiting distinguishes correct holding from a lost or double-taken symbol.

// File: rtl/rank_list_pkg.sv
package rank_list_pkg;
    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_MISS      = 2'd1,
        ACT_PROMOTE   = 2'd2,
        ACT_TRANSPOSE = 2'd3
    } rank_act_e;
endpackage

// File: rtl/rank_cam.sv
module rank_cam #(
    parameter int N  = 368,
    parameter int SW = 9,
    parameter int RW = 9
) (
    input  logic [N-1:0][SW-1:0] tbl,
    input  logic [SW-1:0]        key,
    output logic                 hit,
    output logic [RW-1:0]        pos
);
    // Parallel compare of every slot; lowest matching slot wins.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (tbl[i] == key) begin
                hit = 1'b1;
                pos = RW'(i);
            end
        end
    end
endmodule

// File: rtl/rank_tier.sv
module rank_tier #(
    parameter int N  = 368,
    parameter int K  = 7,
    parameter int RW = 9,
    parameter int CW = 3
) (
    input  logic [K-1:0][RW-1:0] bound,
    input  logic [RW-1:0]        pos,
    output logic [CW-1:0]        cnt,
    output logic                 top,
    output logic [RW-1:0]        tgt
);
    // Tier of a slot = number of boundaries strictly above it.
    always_comb begin
        cnt = '0;
        for (int j = 0; j < K; j++) begin
            if (bound[j] > pos) cnt = cnt + 1'b1;
        end
        top = (cnt == CW'(K));
        tgt = pos;
        if (top) begin
            tgt = (pos == '0) ? '0 : pos - 1'b1;
        end else begin
            for (int j = 0; j < K; j++) begin
                if (CW'(j) == cnt) tgt = bound[j];
            end
        end
    end
endmodule

// File: rtl/rank_list_top.sv
module rank_list_top
    import rank_list_pkg::*;
#(
    parameter int N  = 368,
    parameter int K  = 7,
    parameter int SW = 9,
    localparam int RW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [SW-1:0] in_sym,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [RW-1:0] out_rank
);
    localparam int CW = $clog2(K + 1);
    localparam int SUMW = RW + $clog2(K + 1) + 1;

    typedef struct packed {
        logic [N-1:0][SW-1:0] list;
        logic [K-1:0][RW-1:0] bound;
        logic                 vld;
        logic [RW-1:0]        rank;
    } state_t;

    state_t    st_d, st_q;
    rank_act_e act_d;
    logic      hit;
    logic [RW-1:0] pos, tgt;
    logic [CW-1:0] cnt;
    logic      top;
    logic      fire;

    rank_cam #(.N(N), .SW(SW), .RW(RW)) u_cam (
        .tbl(st_q.list), .key(in_sym), .hit(hit), .pos(pos)
    );

    rank_tier #(.N(N), .K(K), .RW(RW), .CW(CW)) u_tier (
        .bound(st_q.bound), .pos(pos), .cnt(cnt), .top(top), .tgt(tgt)
    );

    assign in_ready  = !st_q.vld || out_ready;
    assign fire      = in_valid && in_ready;
    assign out_valid = st_q.vld;
    assign out_rank  = st_q.rank;

    always_comb begin
        st_d  = st_q;
        act_d = ACT_NONE;
        if (st_q.vld && out_ready) st_d.vld = 1'b0;
        if (fire) begin
            st_d.vld = 1'b1;
            if (!hit) begin
                st_d.rank = '1;
                act_d     = ACT_MISS;
            end else begin
                st_d.rank      = pos;
                st_d.list[tgt] = st_q.list[pos];
                st_d.list[pos] = st_q.list[tgt];
                if (!top) begin
                    st_d.bound[cnt] = st_q.bound[cnt] + 1'b1;
                    act_d = ACT_PROMOTE;
                end else begin
                    act_d = ACT_TRANSPOSE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.list[i] <= SW'(i);
            st_q.bound <= '0;
            st_q.vld   <= 1'b0;
            st_q.rank  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    logic [SUMW-1:0] bound_sum;
    always_comb begin
        bound_sum = '0;
        for (int j = 0; j < K; j++) bound_sum = bound_sum + SUMW'(st_q.bound[j]);
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    a_r2_rank_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rank < RW'(N) || out_rank == '1));

    a_r3_bound_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_d == ACT_PROMOTE) |=> bound_sum == $past(bound_sum) + 1'b1);

    a_r4_bound_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_d != ACT_PROMOTE) |=> $stable(bound_sum));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_rank) && $stable(st_q.bound));

    a_r7_top_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bound[0] <= RW'(N));

    generate
        for (genvar j = 0; j + 1 < K; j++) begin : g_order
            a_r7_bound_order: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.bound[j+1] <= st_q.bound[j]);
        end
    endgenerate
endmodule

// File: tb/rank_list_top_test.sv
`timescale 1ns/1ps
module rank_list_top_test;
    localparam int N  = 16;
    localparam int K  = 3;
    localparam int SW = 5;
    localparam int RW = $clog2(N + 1);
    localparam int MISS = (1 << RW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SW-1:0] in_sym = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [RW-1:0] out_rank;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_list [N];
    int m_bound[K];

    always #2 clk = ~clk;

    rank_list_top #(.N(N), .K(K), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready),
        .out_rank(out_rank)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent list model built from R1..R5.
    task automatic model_step(input int s, output int exp);
        int p, c, t, tmp;
        p = -1;
        for (int i = 0; i < N; i++) if (m_list[i] == s && p < 0) p = i;
        if (p < 0) begin
            exp = MISS;
            return;
        end
        exp = p;
        c = 0;
        for (int j = 0; j < K; j++) if (m_bound[j] > p) c++;
        if (c < K) begin
            t = m_bound[c];
            m_bound[c]++;
        end else begin
            t = (p == 0) ? 0 : p - 1;
        end
        tmp = m_list[p]; m_list[p] = m_list[t]; m_list[t] = tmp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        for (int i = 0; i < N; i++) m_list[i] = i;
        for (int j = 0; j < K; j++) m_bound[j] = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int s, input string req, output int got);
        int exp;
        @(negedge clk);
        in_valid = 1'b1; in_sym = SW'(s); out_ready = 1'b1;
        model_step(s, exp);
        @(negedge clk);
        in_valid = 1'b0;
        got = out_rank;
        check(out_valid && int'(out_rank) == exp, req, int'(out_rank), exp);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int r, exp_b;
        logic [15:0] lfsr;

        // R1: reset state at the ports
        do_reset();
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        // R1: exhaustive first symbol after reset
        for (int s = 0; s < N; s++) begin
            do_reset();
            send(s, "R1 first symbol rank", r);
            check(r == s, "R1 identity load", r, s);
        end

        // R3: hand-worked promotion
        do_reset();
        send(5, "R3 promote 5", r);  check(r == 5, "R3 rank 5 first", r, 5);
        send(5, "R3 promote 5 again", r); check(r == 0, "R3 rank 5 at top", r, 0);
        send(3, "R3 promote 3", r);  check(r == 3, "R3 rank 3", r, 3);
        send(0, "R3 displaced 0", r); check(r == 5, "R3 0 moved to slot 5", r, 5);

        // R4: climb to top tier then transpose
        do_reset();
        for (int k = 0; k < 4; k++) begin
            send(7, "R4 repeat 7", r);
            check(r == ((k == 0) ? 7 : 0), "R4 climb 7", r, (k == 0) ? 7 : 0);
        end
        send(2, "R4 2 first", r);  check(r == 2, "R4 2 first rank", r, 2);
        for (int k = 0; k < 3; k++) begin
            send(2, "R4 2 climb", r); check(r == 1, "R4 2 stays slot 1", r, 1);
        end
        send(7, "R4 transposed 7", r); check(r == 1, "R4 7 pushed to slot 1", r, 1);
        send(2, "R4 transposed back", r); check(r == 1, "R4 2 back at slot 1", r, 1);

        // R5: miss leaves list untouched
        do_reset();
        send(20, "R5 miss", r); check(r == MISS, "R5 miss code", r, MISS);
        send(31, "R5 miss max", r); check(r == MISS, "R5 miss code max", r, MISS);
        send(3, "R5 list unchanged", r); check(r == 3, "R5 3 still at slot 3", r, 3);

        // R6: stall with a second symbol waiting
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_sym = SW'(9); out_ready = 1'b0;
        model_step(9, exp_b);
        @(negedge clk);
        in_sym = SW'(4);
        for (int k = 0; k < 3; k++) begin
            check(out_valid && int'(out_rank) == 9, "R6 held rank", int'(out_rank), 9);
            check(!in_ready, "R6 in_ready low while held", int'(in_ready), 0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        model_step(4, exp_b);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && int'(out_rank) == exp_b, "R6 waiting symbol taken once", int'(out_rank), exp_b);
        @(negedge clk);
        check(!out_valid, "R6 drained", int'(out_valid), 0);
        send(4, "R2 4 promoted once", r);

        // R2/R3/R4/R5: long mixed streams against the model
        do_reset();
        lfsr = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'(lfsr[4:0]), "R2 random full range", r);
        end
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send((lfsr[3:0] < 4'd12) ? int'(lfsr[1:0]) : int'(lfsr[3:0]), "R3 skewed stream", r);
        end
        for (int s = 0; s < 32; s++) send(s, "R2 ascending scan", r);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule